// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into an address in a tiled two-dimensional memory space. The caller supplies a pixel format code, a view code and an (x, y) coordinate with a valid strobe. One clock later the block returns three results: the 32-bit tiled-space address, the line stride of the chosen view, and a flag that marks a coordinate outside the container.

Each format leaves some low coordinate bits unused, so the x and y fields narrow as the pixel size grows. The view code mirrors either axis and can swap the two axes. Together these cover the eight rotation and mirror views of the same buffer. A display or DMA engine uses the address to walk a rotated image and adds the stride to move to the next line.

Top module: `tile_view_addr`

## Requirements
- R1: For an in-range coordinate, address bits [28:27] hold the format code: 0 = 8-bit tiled, 1 = 16-bit tiled, 2 = 32-bit tiled, 3 = page mode.
- R2: For an in-range coordinate, address bits [31:29] hold the 3-bit view code unchanged.
- R3: With the x field width XB = 14 − xs and the y field width YB = 13 − ys, an x above 2^XB − 1 or a y above 2^YB − 1 sets the error flag and forces the address to 0.
- R4: View bit 0 set replaces x with x XOR (2^XB − 1) before packing.
- R5: View bit 1 set replaces y with y XOR (2^YB − 1) before packing.
- R6: View bit 2 set packs the offset as (x << YB) + y.
- R7: View bit 2 clear packs the offset as (y << XB) + x. The packed offset is shifted left by xs + ys and fills address bits [26:0].
- R8: The stride is 1 << (13 + xs) when view bit 2 is set and 1 << (14 + ys) otherwise. It is output even when the coordinate is out of range.
- R9: The results and the result-valid flag appear on the clock edge after an accepted strobe. Result-valid is low in every other cycle and during reset.
- R10: The per-format shifts (xs, ys) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Pixel format code |
| in_view | input | 3 | View code: bit0 mirror x, bit1 mirror y, bit2 swap axes |
| in_x | input | COORD_W (16) | Pixel x coordinate |
| in_y | input | COORD_W (16) | Pixel y coordinate |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_addr | output | ADDR_W (32) | Tiled-space address, 0 on error |
| out_stride | output | ADDR_W (32) | Line stride of the chosen view |
| out_err | output | 1 | Coordinate out of range |

## Verification
The bench uses the default parameters: 14 container width bits, 13 container height bits, 6-bit slot shifts and 16-bit coordinate ports. Because the coordinate ports are wider than any field, a coordinate one step past the mask is reachable for every format. This covers the limit for x and for y in 8-bit, 32-bit and page mode. Every view code is driven with every format. Because the field widths stay fixed, hand-computed addresses for the all-ones corners can be checked next to the model-predicted random traffic.

// File: rtl/tva_pkg.sv
package tva_pkg;

  typedef enum logic [1:0] {
    PIX_B8   = 2'd0,
    PIX_B16  = 2'd1,
    PIX_B32  = 2'd2,
    PIX_PAGE = 2'd3
  } pix_fmt_e;

  // Bit positions inside the view code
  localparam int VIEW_MIRROR_X = 0;
  localparam int VIEW_MIRROR_Y = 1;
  localparam int VIEW_SWAP     = 2;

  localparam int VIEW_W = 3;
  localparam int FMT_W  = 2;

endpackage

// File: rtl/tva_geom.sv
// Format decode: per-axis unused bits, field widths and field masks.
module tva_geom #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int BW      = $clog2(CW_BITS + CH_BITS + 1)
) (
  input  logic [1:0]         fmt,
  output logic [BW-1:0]      x_shift,
  output logic [BW-1:0]      y_shift,
  output logic [BW-1:0]      x_bits,
  output logic [BW-1:0]      y_bits,
  output logic [BW-1:0]      align,
  output logic [CW_BITS-1:0] x_mask,
  output logic [CH_BITS-1:0] y_mask
);
  import tva_pkg::*;

  always_comb begin
    unique case (pix_fmt_e'(fmt))
      PIX_B8:   begin x_shift = BW'(0);       y_shift = BW'(0);       end
      PIX_B16:  begin x_shift = BW'(0);       y_shift = BW'(1);       end
      PIX_B32:  begin x_shift = BW'(1);       y_shift = BW'(1);       end
      default:  begin x_shift = BW'(SW_BITS); y_shift = BW'(SH_BITS); end
    endcase
  end

  assign x_bits = BW'(CW_BITS) - x_shift;
  assign y_bits = BW'(CH_BITS) - y_shift;
  assign align  = x_shift + y_shift;
  assign x_mask = {CW_BITS{1'b1}} >> x_shift;
  assign y_mask = {CH_BITS{1'b1}} >> y_shift;

endmodule

// File: rtl/tva_mapper.sv
// Range check, mirroring and packing of the coordinate into an offset.
module tva_mapper #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int COORD_W = 16,
  parameter int BW      = $clog2(CW_BITS + CH_BITS + 1),
  localparam int OFS_W  = CW_BITS + CH_BITS
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [2:0]         view,
  input  logic [BW-1:0]      x_bits,
  input  logic [BW-1:0]      y_bits,
  input  logic [BW-1:0]      align,
  input  logic [CW_BITS-1:0] x_mask,
  input  logic [CH_BITS-1:0] y_mask,
  output logic [OFS_W-1:0]   offset,
  output logic               range_err
);
  import tva_pkg::*;

  logic               x_over, y_over;
  logic [CW_BITS-1:0] x_mir;
  logic [CH_BITS-1:0] y_mir;
  logic [OFS_W-1:0]   x_ext, y_ext, packed_ofs;

  // A coordinate is legal only when it fits under the field mask
  assign x_over    = x > COORD_W'(x_mask);
  assign y_over    = y > COORD_W'(y_mask);
  assign range_err = x_over | y_over;

  // Mirroring reflects the coordinate inside its own field
  assign x_mir = x[CW_BITS-1:0] ^ (view[VIEW_MIRROR_X] ? x_mask : '0);
  assign y_mir = y[CH_BITS-1:0] ^ (view[VIEW_MIRROR_Y] ? y_mask : '0);

  assign x_ext = OFS_W'(x_mir);
  assign y_ext = OFS_W'(y_mir);

  // Fields never overlap, so the sum equals the OR of the two parts
  always_comb begin
    if (view[VIEW_SWAP]) packed_ofs = (x_ext << y_bits) + y_ext;
    else                 packed_ofs = (y_ext << x_bits) + x_ext;
  end

  assign offset = packed_ofs << align;

endmodule

// File: rtl/tva_stride.sv
// Line stride for the selected view orientation.
module tva_stride #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int ADDR_W  = 32,
  parameter int BW      = $clog2(CW_BITS + CH_BITS + 1),
  localparam int SA_W   = $clog2(ADDR_W) + 1
) (
  input  logic              swap,
  input  logic [BW-1:0]     x_shift,
  input  logic [BW-1:0]     y_shift,
  output logic [ADDR_W-1:0] stride
);
  logic [SA_W-1:0] amount;

  assign amount = swap ? (SA_W'(CH_BITS) + SA_W'(x_shift))
                       : (SA_W'(CW_BITS) + SA_W'(y_shift));
  assign stride = ADDR_W'(1) << amount;

endmodule

// File: rtl/tile_view_addr.sv
// Tiled view address generator: one registered stage from strobe to result.
module tile_view_addr #(
  parameter int CW_BITS     = 14,
  parameter int CH_BITS     = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  parameter int ADDR_W      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_fmt,
  input  logic [2:0]         in_view,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [ADDR_W-1:0]  out_stride,
  output logic               out_err
);
  import tva_pkg::*;

  localparam int OFS_W    = CW_BITS + CH_BITS;
  localparam int BW       = $clog2(OFS_W + 1);
  localparam int FMT_LSB  = OFS_W;
  localparam int VIEW_LSB = OFS_W + FMT_W;

  logic [BW-1:0]      x_shift, y_shift, x_bits, y_bits, align;
  logic [CW_BITS-1:0] x_mask;
  logic [CH_BITS-1:0] y_mask;
  logic [OFS_W-1:0]   offset;
  logic               range_err;
  logic [ADDR_W-1:0]  addr_c, stride_c;

  tva_geom #(
    .CW_BITS (CW_BITS),
    .CH_BITS (CH_BITS),
    .SW_BITS (SLOT_W_BITS),
    .SH_BITS (SLOT_H_BITS),
    .BW      (BW)
  ) u_geom (
    .fmt     (in_fmt),
    .x_shift (x_shift),
    .y_shift (y_shift),
    .x_bits  (x_bits),
    .y_bits  (y_bits),
    .align   (align),
    .x_mask  (x_mask),
    .y_mask  (y_mask)
  );

  tva_mapper #(
    .CW_BITS (CW_BITS),
    .CH_BITS (CH_BITS),
    .COORD_W (COORD_W),
    .BW      (BW)
  ) u_mapper (
    .x         (in_x),
    .y         (in_y),
    .view      (in_view),
    .x_bits    (x_bits),
    .y_bits    (y_bits),
    .align     (align),
    .x_mask    (x_mask),
    .y_mask    (y_mask),
    .offset    (offset),
    .range_err (range_err)
  );

  tva_stride #(
    .CW_BITS (CW_BITS),
    .CH_BITS (CH_BITS),
    .ADDR_W  (ADDR_W),
    .BW      (BW)
  ) u_stride (
    .swap    (in_view[VIEW_SWAP]),
    .x_shift (x_shift),
    .y_shift (y_shift),
    .stride  (stride_c)
  );

  // View code on top, format code below it, offset in the low bits
  assign addr_c = range_err ? '0
                : (ADDR_W'(offset)
                   | (ADDR_W'(in_fmt)  << FMT_LSB)
                   | (ADDR_W'(in_view) << VIEW_LSB));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_stride <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr   <= addr_c;
        out_stride <= stride_c;
        out_err    <= range_err;
      end
    end
  end

  // R9: a strobe yields a result on the next edge
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9: no result without a strobe
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: a rejected coordinate leaves a zero address
  p_err_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_addr == '0));

  // R1: format code lands in its field
  p_fmt_code_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> (out_addr[FMT_LSB +: FMT_W] == $past(in_fmt)));

  // R2: view code lands in its field
  p_view_code_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> (out_addr[VIEW_LSB +: VIEW_W] == $past(in_view)));

  // R8: stride is always a single power of two
  p_stride_pow2_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_stride) == 1));

endmodule

// File: tb/tile_view_addr_bench.sv
module tile_view_addr_bench;
  localparam int CWB = 14;
  localparam int CHB = 13;
  localparam int SWB = 6;
  localparam int SHB = 6;
  localparam int CO  = 16;
  localparam int AW  = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1:0]    in_fmt;
  logic [2:0]    in_view;
  logic [CO-1:0] in_x, in_y;
  logic          out_valid;
  logic [AW-1:0] out_addr, out_stride;
  logic          out_err;

  always #2 clk = ~clk;   // 250 MHz

  tile_view_addr #(
    .CW_BITS (CWB), .CH_BITS (CHB), .SLOT_W_BITS (SWB), .SLOT_H_BITS (SHB),
    .COORD_W (CO), .ADDR_W (AW)
  ) u_tile_view_addr (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_fmt (in_fmt),
    .in_view (in_view), .in_x (in_x), .in_y (in_y), .out_valid (out_valid),
    .out_addr (out_addr), .out_stride (out_stride), .out_err (out_err)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] stride;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // R10 shift table
  function automatic int xs_of(input logic [1:0] f);
    case (f)
      2'd0: return 0;
      2'd1: return 0;
      2'd2: return 1;
      default: return SWB;
    endcase
  endfunction

  function automatic int ys_of(input logic [1:0] f);
    case (f)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 1;
      default: return SHB;
    endcase
  endfunction

  function automatic exp_t model(input logic [1:0] f, input logic [2:0] v,
                                 input int x, input int y);
    exp_t        e;
    int          xs, ys, xb, yb, xm, ym;
    logic [31:0] x2, y2, ofs;
    xs = xs_of(f);
    ys = ys_of(f);
    xb = CWB - xs;
    yb = CHB - ys;
    xm = (1 << xb) - 1;
    ym = (1 << yb) - 1;
    e.stride = 32'd1 << (v[2] ? (CHB + xs) : (CWB + ys));
    if (x > xm || y > ym) begin
      e.err  = 1'b1;
      e.addr = '0;
    end else begin
      e.err = 1'b0;
      x2  = v[0] ? 32'(x ^ xm) : 32'(x);
      y2  = v[1] ? 32'(y ^ ym) : 32'(y);
      ofs = v[2] ? ((x2 << yb) + y2) : ((y2 << xb) + x2);
      ofs = ofs << (xs + ys);
      e.addr = {v, f, ofs[CWB+CHB-1:0]};
    end
    return e;
  endfunction

  task automatic send_exp(input logic [1:0] f, input logic [2:0] v,
                          input int x, input int y, input exp_t e,
                          input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_fmt   = f;
    in_view  = v;
    in_x     = CO'(x);
    in_y     = CO'(y);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [1:0] f, input logic [2:0] v,
                      input int x, input int y, input string tag);
    send_exp(f, v, x, y, model(f, v, x, y), tag);
  endtask

  task automatic send_lit(input logic [1:0] f, input logic [2:0] v,
                          input int x, input int y, input logic [31:0] a,
                          input logic [31:0] s, input logic er, input string tag);
    exp_t e;
    e.addr   = a;
    e.stride = s;
    e.err    = er;
    send_exp(f, v, x, y, e, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: scoreboard compare
  always @(posedge clk) begin
    exp_t  e;
    string t;
    #1;
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected valid", 32'(out_valid), 32'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_err == e.err, t, "err", 32'(out_err), 32'(e.err));
        check(out_addr == e.addr, t, "addr", out_addr, e.addr);
        check(out_stride == e.stride, "R8", "stride", out_stride, e.stride);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    in_valid = 1'b1;
    in_fmt   = 2'd0;
    in_view  = 3'd0;
    in_x     = 16'd5;
    in_y     = 16'd5;
    repeat (3) @(negedge clk);
    // R9: reset state with a strobe held high
    check(out_valid == 1'b0, "R9", "valid in reset", 32'(out_valid), 32'd0);
    check(out_addr == '0, "R9", "addr in reset", out_addr, 32'd0);
    check(out_err == 1'b0, "R9", "err in reset", 32'(out_err), 32'd0);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R9", "valid after reset", 32'(out_valid), 32'd0);

    // R9: single-cycle latency
    send(2'd0, 3'd0, 7, 9, "R9");
    @(posedge clk); #1;
    check(out_valid == 1'b1, "R9", "latency", 32'(out_valid), 32'd1);
    idle(1);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R9", "valid drop", 32'(out_valid), 32'd0);

    // R1: every format code
    for (int f = 0; f < 4; f++) send(2'(f), 3'd0, 1, 1, "R1");
    // R2: every view code in every format
    for (int f = 0; f < 4; f++)
      for (int v = 0; v < 8; v++) send(2'(f), 3'(v), 3, 2, "R2");

    // R7 hand value: 32-bit, x=3 y=2 -> ((2<<13)+3)<<2 | 2<<27
    send_lit(2'd2, 3'd0, 3, 2, 32'h1001000C, 32'h0000_8000, 1'b0, "R7");
    send_lit(2'd0, 3'd0, 1, 1, 32'h0000_4001, 32'h0000_4000, 1'b0, "R7");
    // R10 hand values
    send_lit(2'd3, 3'd0, 255, 127, 32'h1FFFF000, 32'h0010_0000, 1'b0, "R10");
    send_lit(2'd1, 3'd0, 0, 1, 32'h08008000, 32'h0000_8000, 1'b0, "R10");
    // R4 / R5 / R6 hand values
    send_lit(2'd0, 3'd1, 0, 0, 32'h20003FFF, 32'h0000_4000, 1'b0, "R4");
    send_lit(2'd0, 3'd2, 0, 0, 32'h47FFC000, 32'h0000_4000, 1'b0, "R5");
    send_lit(2'd0, 3'd4, 1, 2, 32'h80002002, 32'h0000_2000, 1'b0, "R6");
    send_lit(2'd0, 3'd7, 0, 0, 32'hE7FFFFFF, 32'h0000_2000, 1'b0, "R6");
    send(2'd2, 3'd5, 100, 50, "R6");
    send(2'd3, 3'd3, 17, 9, "R5");

    // R3 limits: last legal and first illegal on each axis
    send_lit(2'd0, 3'd0, 16383, 0, 32'h00003FFF, 32'h0000_4000, 1'b0, "R3");
    send(2'd0, 3'd0, 16384, 0, "R3");
    send(2'd0, 3'd6, 0, 8191, "R3");
    send_lit(2'd0, 3'd7, 0, 8192, 32'h0, 32'h0000_2000, 1'b1, "R3");
    send(2'd2, 3'd0, 8192, 0, "R3");
    send(2'd2, 3'd0, 0, 4096, "R3");
    send(2'd1, 3'd1, 0, 4096, "R3");
    send(2'd3, 3'd0, 256, 0, "R3");
    send(2'd3, 3'd4, 0, 128, "R3");
    send(2'd3, 3'd0, 65535, 65535, "R3");

    // R8 stride in both orientations across formats
    for (int f = 0; f < 4; f++) begin
      send(2'(f), 3'd0, 0, 0, "R8");
      send(2'(f), 3'd4, 0, 0, "R8");
    end

    idle(3);
    check(out_valid == 1'b0, "R9", "idle valid", 32'(out_valid), 32'd0);
    check(exp_q.size() == 0, "R9", "queue drained", 32'(exp_q.size()), 32'd0);

    // Random traffic, back-to-back with occasional gaps (R7, R10)
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] f;
      logic [2:0] v;
      int         xl, yl;
      f  = 2'($urandom_range(0, 3));
      v  = 3'($urandom_range(0, 7));
      xl = 1 << (CWB - xs_of(f));
      yl = 1 << (CHB - ys_of(f));
      if ($urandom_range(0, 7) == 0) idle(1);
      send(f, v, int'($urandom_range(0, xl)), int'($urandom_range(0, yl)), "R7");
    end

    idle(4);
    check(exp_q.size() == 0, "R9", "final queue", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule